// File: doc/BRIEF.md
# Radix-4 Recoded Signed Multiplier

This block multiplies two two's-complement operands of width `W` (8 by default) and returns the full `2W`-bit signed product. The multiplier operand is split into overlapping three-bit windows, and a zero is placed below its least significant bit. Each window becomes one signed digit in the range -2 to +2. Because of this, only `ceil(W/2)` partial products are summed instead of `W`. If `W` is odd, both operands are sign-extended by one bit inside the block, so the digit count is always whole.

Each digit drives three control lines: negate, force-zero and double. A row generator uses them to pick zero, the multiplicand or twice the multiplicand. It then inverts that choice when the digit is negative and adds a one at the row's lowest position to finish the two's complement. Rows are not sign-extended. Each row's sign bit is inverted instead, and one precomputed constant word carries all the leading bits that the extensions would otherwise supply. A carry out of the top product bit is dropped.

Operands are taken with `in_valid` into one input register stage. The product is registered at the output with `out_valid`. A new operand pair may be presented on every cycle.

Top module: `radix4_signed_mul`

## Requirements
- R1: While `rst` is high at a rising edge, both `out_valid` and `out_prod` become zero.
- R2: If `in_valid` is high at rising edge k, `out_valid` is high after edge k+2 for exactly one cycle per accepted pair. Otherwise `out_valid` is low.
- R3: When `out_valid` is high, `out_prod` equals the two's-complement product of the accepted `in_a` and `in_b`, kept to `2W` bits.
- R4: When `in_valid` is low, `in_a` and `in_b` have no effect. No result is produced, and `out_prod` keeps its last value.
- R5: The most negative operand times itself gives the positive value 2^(2W-2) without overflow. The most negative value times the most positive value gives its exact negative.
- R6: Multiplier windows (bit 2i+1, bit 2i, bit 2i-1) map to digits as follows: 000 → 0, 111 → 0, 001 → +1, 010 → +1, 011 → +2, 100 → -2, 101 → -1, 110 → -1. Multipliers made only of the patterns 0x00, 0xFF, 0x55, 0xAA, 0x33, 0xCC, 0x66 and 0x99 give correct products.
- R7: 25 × (-35) with 8-bit operands gives -875, which is 0xFC95.
- R8: 3 × 29 recodes to the digits +1, -1, +2, 0 from the lowest digit upward and gives 87.
- R9: Pairs presented on consecutive cycles each give their own correct product on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present |
| in_a | input | W | Multiplicand, two's complement |
| in_b | input | W | Multiplier, two's complement (recoded) |
| out_valid | output | 1 | Product is present |
| out_prod | output | 2W | Signed product |

## Verification
Every result is due two rising edges after the edge that accepted its operands. The bench keeps its own two-deep queue of expected valid flags, products and tags, and advances that queue once per cycle. It drives inputs and samples outputs at the falling edge, so each comparison lands exactly on the cycle the result is owed. On cycles where no result is due, the same queue expects `out_valid` low and `out_prod` unchanged. Garbage operands driven with `in_valid` low therefore show up as mismatches if they leak through.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Control lines derived from one three-bit multiplier window
  typedef struct packed {
    logic neg;   // subtract the selected multiple
    logic zero;  // select zero magnitude
    logic two;   // select twice the multiplicand
  } booth_ctl_t;
endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import booth_pkg::*;
(
  input  logic [2:0]  grp,   // {b[2i+1], b[2i], b[2i-1]}
  output booth_ctl_t  ctl
);
  always_comb begin
    unique case (grp)
      3'b000:  ctl = '{neg: 1'b0, zero: 1'b1, two: 1'b0};
      3'b001:  ctl = '{neg: 1'b0, zero: 1'b0, two: 1'b0};
      3'b010:  ctl = '{neg: 1'b0, zero: 1'b0, two: 1'b0};
      3'b011:  ctl = '{neg: 1'b0, zero: 1'b0, two: 1'b1};
      3'b100:  ctl = '{neg: 1'b1, zero: 1'b0, two: 1'b1};
      3'b101:  ctl = '{neg: 1'b1, zero: 1'b0, two: 1'b0};
      3'b110:  ctl = '{neg: 1'b1, zero: 1'b0, two: 1'b0};
      default: ctl = '{neg: 1'b1, zero: 1'b1, two: 1'b0};
    endcase
  end

  // R6: a window never asks for zero and double at once
  always_comb begin
    assert_ctl_exclusive_R6: assert (!(ctl.zero && ctl.two));
  end
endmodule

// File: rtl/booth_pp_row.sv
module booth_pp_row
  import booth_pkg::*;
#(
  parameter int EW  = 8,
  parameter int PW  = 16,
  parameter int IDX = 0
) (
  input  logic [EW-1:0] mcand,
  input  booth_ctl_t    ctl,
  output logic [PW-1:0] row
);
  localparam int SHIFT = 2 * IDX;

  logic [EW:0] mag;
  logic [EW:0] pp;
  logic [EW:0] tmpl;

  always_comb begin
    if (ctl.zero)     mag = '0;
    else if (ctl.two) mag = {mcand, 1'b0};
    else              mag = {mcand[EW-1], mcand};
    pp   = mag ^ {(EW+1){ctl.neg}};
    // inverted sign bit replaces the replicated extension
    tmpl = {~pp[EW], pp[EW-1:0]};
    row  = ({{(PW-EW-1){1'b0}}, tmpl} << SHIFT)
         + ({{(PW-1){1'b0}}, ctl.neg} << SHIFT);
  end

  // R6: a zero digit leaves only the template bit and the correction
  always_comb begin
    if (ctl.zero && !ctl.neg)
      assert_zero_row_R6: assert (row == ({{(PW-1){1'b0}}, 1'b1} << (SHIFT + EW)));
  end
endmodule

// File: rtl/booth_row_sum.sv
module booth_row_sum #(
  parameter int PW = 16,
  parameter int NR = 4
) (
  input  logic [NR-1:0][PW-1:0] rows,
  input  logic [PW-1:0]         bias,
  output logic [PW-1:0]         total
);
  logic [NR:0][PW-1:0] acc;

  assign acc[0] = bias;

  for (genvar k = 0; k < NR; k++) begin : g_add
    assign acc[k+1] = acc[k] + rows[k];
  end

  assign total = acc[NR];
endmodule

// File: rtl/radix4_signed_mul.sv
module radix4_signed_mul
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  output logic [2*W-1:0] out_prod
);
  localparam int EW  = W + (W % 2);
  localparam int NPP = EW / 2;
  localparam int PW  = 2 * EW;
  localparam int OW  = 2 * W;

  // sum of the constants left over when each row's sign bit is inverted
  function automatic logic [PW-1:0] tpl_const();
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NPP; i++)
      acc = acc - ({{(PW-1){1'b0}}, 1'b1} << (EW + 2*i));
    return acc;
  endfunction

  localparam logic [PW-1:0] BIAS = tpl_const();

  logic          v_q;
  logic [W-1:0]  a_q, b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        a_q <= in_a;
        b_q <= in_b;
      end
    end
  end

  logic [EW-1:0] a_x, b_x;
  logic [EW:0]   b_pad;

  generate
    if (EW == W) begin : g_even
      assign a_x = a_q;
      assign b_x = b_q;
    end else begin : g_odd
      assign a_x = {a_q[W-1], a_q};
      assign b_x = {b_q[W-1], b_q};
    end
  endgenerate

  assign b_pad = {b_x, 1'b0};

  booth_ctl_t                ctl  [NPP];
  logic [NPP-1:0][PW-1:0]    rows;
  logic [PW-1:0]             total;

  for (genvar i = 0; i < NPP; i++) begin : g_digit
    booth_enc u_enc (
      .grp (b_pad[2*i+2 -: 3]),
      .ctl (ctl[i])
    );
    booth_pp_row #(.EW(EW), .PW(PW), .IDX(i)) u_row (
      .mcand (a_x),
      .ctl   (ctl[i]),
      .row   (rows[i])
    );
  end

  booth_row_sum #(.PW(PW), .NR(NPP)) u_sum (
    .rows  (rows),
    .bias  (BIAS),
    .total (total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= v_q;
      if (v_q) out_prod <= total[OW-1:0];
    end
  end

  // behavioural reference used only by the checks below
  logic signed [OW-1:0] ref_w;
  assign ref_w = $signed(a_q) * $signed(b_q);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  assert_product_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_prod == $past(ref_w));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !v_q |=> $stable(out_prod));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (v_q && a_q == {1'b1, {(W-1){1'b0}}} && b_q == {1'b1, {(W-1){1'b0}}})
      |=> out_prod == ({{(OW-1){1'b0}}, 1'b1} << (OW-2)));
endmodule

// File: tb/radix4_signed_mul_tb_top.sv
module radix4_signed_mul_tb_top;
  localparam int W  = 8;
  localparam int OW = 2 * W;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [W-1:0]  in_a, in_b;
  logic          out_valid;
  logic [OW-1:0] out_prod;

  always #10 clk = ~clk;

  radix4_signed_mul #(.W(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_prod  (out_prod)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // expected-result queue, two deep
  logic          q1_v = 0, q2_v = 0;
  logic [OW-1:0] q1_p = '0, q2_p = '0;
  string         q1_t = "", q2_t = "";
  logic [OW-1:0] held = '0;

  function automatic logic [OW-1:0] mul_ref(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [OW-1:0] sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    return sa * sb;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: check what is due now, then drive the next inputs
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    chk(out_valid == q2_v, "R2 valid", {{(OW-1){1'b0}}, out_valid}, {{(OW-1){1'b0}}, q2_v});
    if (q2_v) begin
      chk(out_prod == q2_p, q2_t, out_prod, q2_p);
      held = q2_p;
    end else begin
      chk(out_prod == held, "R4 hold", out_prod, held);
    end
    q2_v = q1_v; q2_p = q1_p; q2_t = q1_t;
    q1_v = v;    q1_p = mul_ref(a, b); q1_t = tag;
    in_valid = v; in_a = a; in_b = b;
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [8];
    void'($urandom(32'd24680));
    rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 valid", {{(OW-1){1'b0}}, out_valid}, '0);
    chk(out_prod == '0, "R1 prod", out_prod, '0);
    @(negedge clk);
    rst = 1'b0;

    step(1, 8'd25, 8'hDD, "R7 25*-35");
    step(1, 8'd3, 8'd29, "R8 3*29");
    step(1, 8'h80, 8'h80, "R5 min*min");
    step(1, 8'h80, 8'h7F, "R5 min*max");
    step(1, 8'h7F, 8'h80, "R5 max*min");
    step(1, 8'h7F, 8'h7F, "R3 max*max");
    step(1, 8'hFF, 8'hFF, "R3 -1*-1");
    step(1, 8'h00, 8'h93, "R3 zero a");
    step(1, 8'h5A, 8'h00, "R3 zero b");

    // R4: garbage with in_valid low
    for (int k = 0; k < 4; k++) step(0, 8'($urandom), 8'($urandom), "R4 idle");

    pats = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h33, 8'hCC, 8'h66, 8'h99};
    for (int k = 0; k < 8; k++) begin
      step(1, 8'($urandom), pats[k], "R6 window");
      step(1, 8'h80, pats[k], "R6 window min");
    end

    // R9: back-to-back random burst, then mixed gaps
    for (int k = 0; k < 200; k++) step(1, 8'($urandom), 8'($urandom), "R9 burst");
    for (int k = 0; k < 400; k++) step(($urandom % 3) != 0, 8'($urandom), 8'($urandom), "R3 random");
    for (int k = 0; k < 3; k++) step(0, 8'($urandom), 8'($urandom), "R4 drain");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule